// File: doc/BRIEF.md
# Nine-bit serial command writer

This block sends one byte at a time to a display controller over a three-wire serial link that only writes. Each byte is marked as either a command or a parameter. Instead of driving a separate data/command pin, the block places that mark on the wire as an extra leading bit, so every serial word is nine bits long.

A requester offers a byte and its kind flag on a valid/ready handshake. The block then takes chip select low and shifts the word out, most significant bit first. It releases chip select at the end and raises a one-cycle completion pulse. The serial clock comes from the system clock: each half period of the serial clock lasts `DIV+1` system clocks, so the serial rate is the system clock divided by `2*(DIV+1)`. The controller samples on the rising edge of the serial clock. The block changes data only on the falling edge.

Top module: `spi9_tx`

## Requirements
- R1: Each chip-select-low window contains exactly 9 rising edges of `sclk`.
- R2: The first bit on `sdo` is the kind flag (0 = command, 1 = parameter). The 8 payload bits follow, bit 7 first and bit 0 last.
- R3: While the block is active, `sdo` changes only in the cycle where `sclk` has just fallen or `csN` has just fallen.
- R4: Within a word, every high phase and every low phase of `sclk` lasts exactly `DIV+1` system clocks.
- R5: The first rising edge of `sclk` comes `DIV+1` clocks after `csN` falls. `csN` rises `DIV+1` clocks after the last falling edge of `sclk`. `sclk` is low whenever `csN` is high.
- R6: A request is accepted on a clock edge where both `reqValid` and `reqReady` are high. `csN` is low in the cycle that follows.
- R7: A request offered while `reqReady` is low is not accepted. It starts no transfer and does not change the word being sent.
- R8: `done` is high for exactly the one cycle in which `csN` has just returned high.
- R9: Reset, including a reset in the middle of a word, drives `csN` high, `sclk` low, `sdo` low, `done` low and `reqReady` high.
- R10: `reqReady` rises in the same cycle that `csN` returns high. A request that is held pending is accepted on the next edge, which leaves `csN` high for exactly one cycle between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqKind | input | 1 | 0 = command byte, 1 = parameter byte |
| reqByte | input | PAYLOAD_W | Payload byte |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| done | output | 1 | One-cycle pulse when a word has been sent |

## Verification
A vector table sends both kinds of word with several payloads: all zeros, all ones, alternating bits and mixed values. This shows whether the kind flag lands in the leading position and whether payload bits come out in the right order. A word with both kinds set to all ones shows whether the flag is captured separately from the payload. Timing is measured edge by edge, which separates a correct divider from one that is off by a cycle and shows whether data moves on the wrong clock edge. Directed tests then offer a request while the block is busy, hold a request pending across a word boundary, and assert reset in the middle of a word.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

  // Phase of the word being sent.
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } phase_e;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic load;   // capture a new word, select the target
    logic rise;   // drive the serial clock high
    logic fall;   // drive the serial clock low, move to the next bit
    logic drop;   // deselect the target, flag completion
  } strobe_t;

endpackage

// File: rtl/spi9_halftimer.sv
module spi9_halftimer #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic clr,
  output logic expire
);
  localparam int CW = (DIV > 0) ? $clog2(DIV + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV);

  logic [CW-1:0] count;

  // Asserted in the last system clock of a half period.
  assign expire = run && (count == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr || expire) begin
      count <= '0;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/spi9_ctrl.sv
module spi9_ctrl
  import spi9_pkg::*;
#(
  parameter int DIV    = 1,
  parameter int WORD_W = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t strb
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  phase_e        phase, phaseNxt;
  logic [BW-1:0] bitIdx;
  logic          expire;
  logic          run;

  assign run      = (phase != ST_IDLE);
  assign reqReady = (phase == ST_IDLE);

  spi9_halftimer #(.DIV(DIV)) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .clr    (strb.load),
    .expire (expire)
  );

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    unique case (phase)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          phaseNxt  = ST_LOW;
        end
      end
      ST_LOW: begin
        if (expire) begin
          strb.rise = 1'b1;
          phaseNxt  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (expire) begin
          strb.fall = 1'b1;
          phaseNxt  = (bitIdx == LAST_BIT) ? ST_TAIL : ST_LOW;
        end
      end
      ST_TAIL: begin
        if (expire) begin
          strb.drop = 1'b1;
          phaseNxt  = ST_IDLE;
        end
      end
      default: phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      phase <= phaseNxt;
      if (strb.load) begin
        bitIdx <= '0;
      end else if (strb.fall && (bitIdx != LAST_BIT)) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi9_dpath.sv
module spi9_dpath
  import spi9_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] word,
  output logic              csN,
  output logic              sclk,
  output logic              sdo,
  output logic              done
);
  logic [WORD_W-1:0] shiftReg;

  // The line always carries the head of the shifter. Once all bits are
  // out, zeros have been shifted in, so the line returns low.
  assign sdo = shiftReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= strb.drop;
      if (strb.load) begin
        shiftReg <= word;
        csN      <= 1'b0;
      end
      if (strb.rise) begin
        sclk <= 1'b1;
      end
      if (strb.fall) begin
        sclk     <= 1'b0;
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end
      if (strb.drop) begin
        csN <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi9_tx.sv
module spi9_tx
  import spi9_pkg::*;
#(
  parameter int DIV       = 1,
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqKind,
  input  logic [PAYLOAD_W-1:0] reqByte,
  output logic                 csN,
  output logic                 sclk,
  output logic                 sdo,
  output logic                 done
);
  localparam int WORD_W = PAYLOAD_W + 1;

  strobe_t strb;

  spi9_ctrl #(.DIV(DIV), .WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strb     (strb)
  );

  spi9_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .word ({reqKind, reqByte}),
    .csN  (csN),
    .sclk (sclk),
    .sdo  (sdo),
    .done (done)
  );
endmodule

// File: rtl/spi9_tx_chk.sv
module spi9_tx_chk #(
  parameter int PAYLOAD_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic csN,
  input logic sclk,
  input logic sdo,
  input logic done
);
  localparam int WORD_W = PAYLOAD_W + 1;
  localparam int RW = $clog2(WORD_W + 1) + 1;

  logic          prevSclk, prevCs;
  logic [RW-1:0] riseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk <= 1'b0;
      prevCs   <= 1'b1;
      riseCnt  <= '0;
    end else begin
      prevSclk <= sclk;
      prevCs   <= csN;
      if (!csN && prevCs) begin
        riseCnt <= '0;
      end else if (sclk && !prevSclk) begin
        riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  assert_nine_edges_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !prevCs) |-> (riseCnt == RW'(WORD_W)));

  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$fell(sclk) && !$fell(csN)) |-> $stable(sdo));

  assert_idle_clock_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_accept_selects_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !csN);

  assert_done_with_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

  assert_ready_tracks_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == csN);
endmodule

bind spi9_tx spi9_tx_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .csN      (csN),
  .sclk     (sclk),
  .sdo      (sdo),
  .done     (done)
);

// File: tb/spi9_tx_tb.sv
module spi9_tx_tb;
  localparam int DIV  = 1;
  localparam int HALF = DIV + 1;
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    9'h011, 9'h1A4, 9'h0FF, 9'h100, 9'h155, 9'h0AA, 9'h1FF, 9'h000
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqKind = 1'b0;
  logic [7:0] reqByte = '0;
  logic       reqReady, csN, sclk, sdo, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi9_tx #(.DIV(DIV), .PAYLOAD_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqByte(reqByte), .csN(csN), .sclk(sclk),
    .sdo(sdo), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor sampled on the falling system clock edge
  logic       prevS = 1'b0, prevC = 1'b1, prevD = 1'b0;
  int         csFallCyc = 0, csRiseCyc = 0, lastRiseCyc = 0, lastFallCyc = 0;
  int         nRise = 0, frameCnt = 0, lastGap = 0;
  logic [8:0] cap = '0, lastWord = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!csN && prevC) begin
        csFallCyc = cyc; nRise = 0; cap = '0; lastGap = cyc - csRiseCyc;
      end
      if (sdo != prevD)
        chk((prevS && !sclk) || (prevC && !csN), "R3 sdo moved off falling edge", sdo, prevD);
      if (sclk && !prevS) begin
        if (nRise == 0) chk(cyc - csFallCyc == HALF, "R5 select lead", cyc - csFallCyc, HALF);
        else            chk(cyc - lastFallCyc == HALF, "R4 low phase", cyc - lastFallCyc, HALF);
        nRise++;
        cap = {cap[7:0], sdo};
        lastRiseCyc = cyc;
      end
      if (!sclk && prevS) begin
        chk(cyc - lastRiseCyc == HALF, "R4 high phase", cyc - lastRiseCyc, HALF);
        lastFallCyc = cyc;
      end
      if (csN && !prevC) begin
        chk(nRise == 9, "R1 edge count", nRise, 9);
        chk(cyc - lastFallCyc == HALF, "R5 select trail", cyc - lastFallCyc, HALF);
        chk(done, "R8 done at release", done, 1);
        chk(reqReady, "R10 ready at release", reqReady, 1);
        lastWord = cap;
        frameCnt++;
        csRiseCyc = cyc;
      end else if (done) begin
        chk(1'b0, "R8 done without release", done, 0);
      end
    end
    prevS = sclk; prevC = csN; prevD = sdo;
  end

  task automatic send(input logic k, input logic [7:0] b);
    reqKind = k; reqByte = b; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!csN, "R6 select after accept", csN, 0);
  endtask

  task automatic waitFrame(input int startCnt);
    while (frameCnt == startCnt) @(negedge clk);
  endtask

  task automatic checkIdle(input string tag);
    chk(csN == 1'b1, tag, csN, 1);
    chk(sclk == 1'b0, tag, sclk, 0);
    chk(sdo == 1'b0, tag, sdo, 0);
    chk(reqReady == 1'b1, tag, reqReady, 1);
    chk(done == 1'b0, tag, done, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    checkIdle("R9 reset state");
    rstN = 1'b1;
    @(negedge clk);

    // R2: vector table, both kinds, varied payloads
    for (int i = 0; i < NVEC; i++) begin
      base = frameCnt;
      send(VEC[i][8], VEC[i][7:0]);
      waitFrame(base);
      chk(lastWord == VEC[i], "R2 word content", lastWord, VEC[i]);
      @(negedge clk);
    end

    // R7: request offered while busy is ignored
    base = frameCnt;
    send(1'b0, 8'h3C);
    reqKind = 1'b1; reqByte = 8'hC3; reqValid = 1'b1;
    repeat (5) @(negedge clk);
    reqValid = 1'b0;
    waitFrame(base);
    chk(lastWord == 9'h03C, "R7 busy request altered word", lastWord, 9'h03C);
    repeat (8) @(negedge clk);
    chk(frameCnt == base + 1, "R7 busy request started word", frameCnt, base + 1);
    chk(csN == 1'b1, "R7 select after ignored request", csN, 1);

    // R10: pending request accepted right after release
    base = frameCnt;
    send(1'b1, 8'h5A);
    reqKind = 1'b0; reqByte = 8'h81; reqValid = 1'b1;
    waitFrame(base);
    chk(lastWord == 9'h15A, "R10 first of pair", lastWord, 9'h15A);
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitFrame(base + 1);
    chk(lastGap == 1, "R10 gap between words", lastGap, 1);
    chk(lastWord == 9'h081, "R10 second of pair", lastWord, 9'h081);

    // R9: reset in the middle of a word
    @(negedge clk);
    base = frameCnt;
    send(1'b1, 8'hFF);
    repeat (7) @(negedge clk);
    #3 rstN = 1'b0;
    @(negedge clk);
    checkIdle("R9 mid-word reset");
    #3 rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(frameCnt == base, "R9 no word after reset", frameCnt, base);
    chk(csN == 1'b1, "R9 stays idle", csN, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule